// File: doc/BRIEF.md
# Companion-Chip System Control and GPIO Output Unit

This block is the byte-wide control register file of a companion I/O chip. A host writes and reads single bytes at 8-bit offsets. The block holds a fixed revision byte and an interrupt status/mask pair. It also holds sixteen general-purpose output pins, each with a data bit and an output-enable bit. Wider vectors are split into little-endian byte lanes.

Up to eight sub-device interrupt lines feed the status byte. By index they are: 0 flash controller, 1 card slot, 2 USB host, 3 serial port, 4 display controller. The single host interrupt is the OR of status AND mask. Each pin drives its data bit qualified by its enable bit. Whenever a data or enable lane is written, a one-cycle change pulse marks exactly the pins whose qualified level moved.

All pins are plain control and status signals. No interface carries a data stream, so nothing here applies back-pressure. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`.

Top module: `ioc_sysctl`

## Requirements
- R1: After reset, the status, mask, output data, output enable and previous-level registers are all zero, so `host_irq`, `gpio_out` and `gpio_toggle` are 0.
- R2: A read at offset 0x08 returns the `REV_ID` parameter, and a write to 0x08 leaves that value unchanged.
- R3: When a `sub_irq` bit changes, the status bit of the same index (readable at offset 0x50, bit i = input i) takes the new input level at the next clock edge.
- R4: The mask byte is read and written at offset 0x52. `host_irq` is high exactly when some bit is set in both status and mask, and it follows register changes without extra delay.
- R5: A host write to offset 0x50 replaces the status bits whose input did not change in that cycle. A bit whose input changes in the same cycle takes the input level instead.
- R6: Output data lanes sit at 0x78 (pins 7..0) and 0x79 (pins 15..8). A byte write replaces only its own lane, and each lane reads back what was written.
- R7: Output enable lanes sit at 0x7C (pins 7..0) and 0x7D (pins 15..8), with the same per-lane replace and read-back rule.
- R8: `gpio_out[i]` is data bit i AND enable bit i. A pin whose enable is clear drives 0.
- R9: In the cycle after a write to any data or enable lane, `gpio_toggle` is high for exactly the pins whose qualified level differs from the level before the write. In every other cycle it is 0.
- R10: Lane 2 of data (0x7A) and enable (0x7E) lies beyond the sixteen pins. It reads 0x00, and writes to it change no pin.
- R11: Any other offset reads 0x00, and a write there changes no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| sub_irq | input | NUM_IRQ (8) | Sub-device interrupt levels |
| host_irq | output | 1 | Masked interrupt to the host |
| gpio_out | output | NUM_GPIO (16) | Qualified pin levels |
| gpio_toggle | output | NUM_GPIO (16) | One-cycle pulse per pin whose qualified level changed |

## Verification
The bench sets `REV_ID` to 0xA5, so the fixed revision read cannot be mistaken for a reset-zero or an all-ones value. It keeps `NUM_GPIO` at 16 and `NUM_IRQ` at 8. With those values the third byte lane is a real address with no pins behind it, which exercises the drop rule on lane 2. The full interrupt byte is also in use, so the clash between an input change and a status write can be tested on individual bits.

// File: rtl/ioc_sysctl_pkg.sv
package ioc_sysctl_pkg;
  localparam int ADDR_W     = 8;
  localparam int GPIO_LANES = 3;

  localparam logic [ADDR_W-1:0] OFS_REV   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h52;
  localparam logic [ADDR_W-1:0] OFS_DATA0 = 8'h78;
  localparam logic [ADDR_W-1:0] OFS_EN0   = 8'h7C;

  typedef logic [7:0] byte_t;
endpackage

// File: rtl/ioc_irq_gather.sv
module ioc_irq_gather #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] sub_irq,
  input  logic               wr_stat,
  input  logic               wr_mask,
  input  logic [NUM_IRQ-1:0] wdata,
  output logic [NUM_IRQ-1:0] status_q,
  output logic [NUM_IRQ-1:0] mask_q,
  output logic               host_irq
);
  logic [NUM_IRQ-1:0] in_prev_q;
  logic [NUM_IRQ-1:0] edge_seen;
  logic [NUM_IRQ-1:0] base_v;
  logic [NUM_IRQ-1:0] status_nxt;

  // An input that moved this cycle overrides a host write to the same bit
  assign edge_seen  = sub_irq ^ in_prev_q;
  assign base_v     = wr_stat ? wdata : status_q;
  assign status_nxt = (edge_seen & sub_irq) | (~edge_seen & base_v);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_prev_q <= '0;
      status_q  <= '0;
      mask_q    <= '0;
    end else begin
      in_prev_q <= sub_irq;
      status_q  <= status_nxt;
      if (wr_mask) mask_q <= wdata;
    end
  end

  assign host_irq = |(status_q & mask_q);
endmodule

// File: rtl/ioc_gpio_lanes.sv
module ioc_gpio_lanes #(
  parameter int NUM_GPIO = 16,
  parameter int LANES    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES-1:0]    wr_data_lane,
  input  logic [LANES-1:0]    wr_en_lane,
  input  logic [7:0]          wdata,
  output logic [8*LANES-1:0]  data_vec,
  output logic [8*LANES-1:0]  en_vec,
  output logic [NUM_GPIO-1:0] en_q,
  output logic [NUM_GPIO-1:0] pin_out,
  output logic [NUM_GPIO-1:0] pin_toggle
);
  localparam int VEC_W = 8 * LANES;

  logic [NUM_GPIO-1:0] data_q;
  logic [NUM_GPIO-1:0] prev_q;
  logic [VEC_W-1:0]    data_nxt_v;
  logic [VEC_W-1:0]    en_nxt_v;
  logic [NUM_GPIO-1:0] qual_nxt;
  logic                any_wr;

  assign data_vec = VEC_W'(data_q);
  assign en_vec   = VEC_W'(en_q);

  // Each lane replaces only its own byte of the wide vectors
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign data_nxt_v[8*g +: 8] = wr_data_lane[g] ? wdata : data_vec[8*g +: 8];
    assign en_nxt_v[8*g +: 8]   = wr_en_lane[g]   ? wdata : en_vec[8*g +: 8];
  end

  assign any_wr   = |{wr_data_lane, wr_en_lane};
  assign qual_nxt = data_nxt_v[NUM_GPIO-1:0] & en_nxt_v[NUM_GPIO-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q     <= '0;
      en_q       <= '0;
      prev_q     <= '0;
      pin_toggle <= '0;
    end else begin
      data_q <= data_nxt_v[NUM_GPIO-1:0];
      en_q   <= en_nxt_v[NUM_GPIO-1:0];
      if (any_wr) begin
        pin_toggle <= qual_nxt ^ prev_q;
        prev_q     <= qual_nxt;
      end else begin
        pin_toggle <= '0;
      end
    end
  end

  assign pin_out = data_q & en_q;
endmodule

// File: rtl/ioc_sysctl.sv
module ioc_sysctl
  import ioc_sysctl_pkg::*;
#(
  parameter int          NUM_IRQ  = 8,
  parameter int          NUM_GPIO = 16,
  parameter logic [7:0]  REV_ID   = 8'h03
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          bus_addr,
  input  logic                bus_wr,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  input  logic [NUM_IRQ-1:0]  sub_irq,
  output logic                host_irq,
  output logic [NUM_GPIO-1:0] gpio_out,
  output logic [NUM_GPIO-1:0] gpio_toggle
);
  localparam int VEC_W = 8 * GPIO_LANES;

  logic [NUM_IRQ-1:0]    status_q;
  logic [NUM_IRQ-1:0]    mask_q;
  logic [NUM_GPIO-1:0]   gpio_en_q;
  logic [VEC_W-1:0]      data_vec;
  logic [VEC_W-1:0]      en_vec;
  logic [GPIO_LANES-1:0] wr_data_lane;
  logic [GPIO_LANES-1:0] wr_en_lane;
  logic                  wr_stat;
  logic                  wr_mask;

  assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
  assign wr_mask = bus_wr && (bus_addr == OFS_MASK);

  for (genvar g = 0; g < GPIO_LANES; g++) begin : g_dec
    assign wr_data_lane[g] = bus_wr && (bus_addr == OFS_DATA0 + 8'(g));
    assign wr_en_lane[g]   = bus_wr && (bus_addr == OFS_EN0 + 8'(g));
  end

  ioc_irq_gather #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sub_irq  (sub_irq),
    .wr_stat  (wr_stat),
    .wr_mask  (wr_mask),
    .wdata    (bus_wdata[NUM_IRQ-1:0]),
    .status_q (status_q),
    .mask_q   (mask_q),
    .host_irq (host_irq)
  );

  ioc_gpio_lanes #(.NUM_GPIO(NUM_GPIO), .LANES(GPIO_LANES)) u_gpio (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_data_lane (wr_data_lane),
    .wr_en_lane   (wr_en_lane),
    .wdata        (bus_wdata),
    .data_vec     (data_vec),
    .en_vec       (en_vec),
    .en_q         (gpio_en_q),
    .pin_out      (gpio_out),
    .pin_toggle   (gpio_toggle)
  );

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == OFS_REV)  bus_rdata = REV_ID;
    if (bus_addr == OFS_STAT) bus_rdata = 8'(status_q);
    if (bus_addr == OFS_MASK) bus_rdata = 8'(mask_q);
    for (int i = 0; i < GPIO_LANES; i++) begin
      if (bus_addr == OFS_DATA0 + 8'(i)) bus_rdata = data_vec[8*i +: 8];
      if (bus_addr == OFS_EN0 + 8'(i))   bus_rdata = en_vec[8*i +: 8];
    end
  end
endmodule

// File: rtl/ioc_sysctl_chk.sv
module ioc_sysctl_chk #(
  parameter int NUM_IRQ  = 8,
  parameter int NUM_GPIO = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [NUM_IRQ-1:0]  sub_irq,
  input logic                host_irq,
  input logic [NUM_IRQ-1:0]  status_q,
  input logic [NUM_IRQ-1:0]  mask_q,
  input logic [NUM_GPIO-1:0] gpio_en_q,
  input logic [NUM_GPIO-1:0] gpio_out,
  input logic [NUM_GPIO-1:0] gpio_toggle
);
  // R3
  stat_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((status_q ^ $past(sub_irq)) & ($past(sub_irq) ^ $past(sub_irq, 2))) == '0));

  // R4
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !host_irq);

  // R8
  pin_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_out & ~gpio_en_q) == '0);

  // R9
  toggle_matches_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (gpio_toggle == (gpio_out ^ $past(gpio_out))));

  // R9
  toggle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (gpio_toggle == '0));
endmodule

bind ioc_sysctl ioc_sysctl_chk #(.NUM_IRQ(NUM_IRQ), .NUM_GPIO(NUM_GPIO)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .sub_irq     (sub_irq),
  .host_irq    (host_irq),
  .status_q    (status_q),
  .mask_q      (mask_q),
  .gpio_en_q   (gpio_en_q),
  .gpio_out    (gpio_out),
  .gpio_toggle (gpio_toggle)
);

// File: tb/test_ioc_sysctl.sv
`timescale 1ns/1ps
module test_ioc_sysctl;
  typedef enum logic [1:0] {S_RD, S_IRQ, S_OUT, S_TOG} sel_e;
  typedef struct {
    sel_e        sel;
    logic [15:0] val;
    string       tag;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [7:0]  sub_irq;
  logic        host_irq;
  logic [15:0] gpio_out;
  logic [15:0] gpio_toggle;

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  item_t exp_q[$];

  ioc_sysctl #(.NUM_IRQ(8), .NUM_GPIO(16), .REV_ID(8'hA5)) i_ioc_sysctl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sub_irq(sub_irq),
    .host_irq(host_irq), .gpio_out(gpio_out), .gpio_toggle(gpio_toggle)
  );

  initial begin
    clk = 0;
    forever #4 clk = ~clk;
  end

  task automatic expect_val(sel_e sel, logic [15:0] val, string tag);
    item_t it;
    it.sel = sel; it.val = val; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] d, string tag);
    bus_addr = a;
    expect_val(S_RD, {8'h00, d}, tag);
    @(negedge clk);
  endtask

  // Monitor: pops expectations shortly after each falling edge
  initial begin
    item_t it;
    logic [15:0] got;
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        case (it.sel)
          S_RD:    got = {8'h00, bus_rdata};
          S_IRQ:   got = {15'h0, host_irq};
          S_OUT:   got = gpio_out;
          default: got = gpio_toggle;
        endcase
        checks++;
        if (got !== it.val) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, got, it.val);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_addr = 0; bus_wr = 0; bus_wdata = 0; sub_irq = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    expect_val(S_OUT, 16'h0000, "R1 gpio_out");
    expect_val(S_TOG, 16'h0000, "R1 gpio_toggle");
    expect_val(S_IRQ, 16'h0000, "R1 host_irq");
    rd(8'h50, 8'h00, "R1 status");
    rd(8'h52, 8'h00, "R1 mask");
    rd(8'h78, 8'h00, "R1 data lane0");
    rd(8'h7D, 8'h00, "R1 enable lane1");
    // R2 revision
    rd(8'h08, 8'hA5, "R2 revision");
    wr(8'h08, 8'hFF);
    rd(8'h08, 8'hA5, "R2 revision after write");
    // R11 unimplemented offset
    rd(8'h10, 8'h00, "R11 read");
    wr(8'h10, 8'hFF);
    expect_val(S_OUT, 16'h0000, "R11 gpio_out");
    rd(8'h10, 8'h00, "R11 read after write");
    rd(8'h52, 8'h00, "R11 mask untouched");
    // R3 status follows inputs
    sub_irq = 8'h05;
    @(negedge clk);
    rd(8'h50, 8'h05, "R3 status capture");
    expect_val(S_IRQ, 16'h0000, "R4 masked off");
    // R4 mask
    wr(8'h52, 8'h04);
    expect_val(S_IRQ, 16'h0001, "R4 irq on");
    rd(8'h52, 8'h04, "R4 mask readback");
    sub_irq = 8'h01;
    @(negedge clk);
    rd(8'h50, 8'h01, "R3 status clear");
    expect_val(S_IRQ, 16'h0000, "R4 irq off");
    // R5 host write to status
    wr(8'h50, 8'h80);
    rd(8'h50, 8'h80, "R5 status write");
    wr(8'h52, 8'h80);
    expect_val(S_IRQ, 16'h0001, "R4 irq from written status");
    sub_irq = 8'h03;
    wr(8'h50, 8'h00);
    rd(8'h50, 8'h02, "R5 input change wins");
    // GPIO R6..R10
    wr(8'h78, 8'hFF);
    expect_val(S_OUT, 16'h0000, "R8 no enable");
    expect_val(S_TOG, 16'h0000, "R9 no change");
    wr(8'h7C, 8'h0F);
    expect_val(S_OUT, 16'h000F, "R8 enable lane0");
    expect_val(S_TOG, 16'h000F, "R9 pulse lane0");
    @(negedge clk);
    expect_val(S_TOG, 16'h0000, "R9 pulse one cycle");
    wr(8'h79, 8'hA5);
    expect_val(S_OUT, 16'h000F, "R8 lane1 disabled");
    expect_val(S_TOG, 16'h0000, "R9 lane1 no pulse");
    rd(8'h78, 8'hFF, "R6 lane0 kept");
    rd(8'h79, 8'hA5, "R6 lane1 readback");
    wr(8'h7D, 8'hFF);
    expect_val(S_OUT, 16'hA50F, "R8 both lanes");
    expect_val(S_TOG, 16'hA500, "R9 pulse lane1");
    wr(8'h78, 8'hF0);
    expect_val(S_OUT, 16'hA500, "R8 masked lane0");
    expect_val(S_TOG, 16'h000F, "R9 pulse falling bits");
    rd(8'h7C, 8'h0F, "R7 enable lane0");
    rd(8'h7D, 8'hFF, "R7 enable lane1");
    wr(8'h7A, 8'hFF);
    expect_val(S_OUT, 16'hA500, "R10 data lane2 out");
    expect_val(S_TOG, 16'h0000, "R10 data lane2 pulse");
    rd(8'h7A, 8'h00, "R10 data lane2 read");
    wr(8'h7E, 8'hFF);
    expect_val(S_OUT, 16'hA500, "R10 enable lane2 out");
    rd(8'h7E, 8'h00, "R10 enable lane2 read");
    rd(8'h79, 8'hA5, "R10 lane1 untouched");
    @(negedge clk);
    #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule